// File: doc/BRIEF.md
# Serial Control Port for a Dual-Loop Frequency Synthesizer

This block is the programming front end of a two-loop frequency synthesizer. A host drives three slow pins: a serial clock, a serial data line and a load strobe. Each rising edge of the serial clock moves one data bit into a 22-bit shift register, most significant bit first. The last two bits shifted in form a two-bit address.

When the load strobe rises, the 20 bits above that address are copied into one of four parallel setting registers. Examples are the reference and programmable divider settings for each loop. Every register has a one-cycle update strobe. The current shift register contents are also visible on a parallel diagnostic output.

All three pins are asynchronous to the system clock. They are brought into the system clock domain through a synchronizer chain, and their rising edges are detected there. The host must hold each pin level for several system clock cycles.

Top module: `synth_cfg_port`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), the shift view, all four setting registers and all update strobes are zero.
- R2: Each rising edge of the serial clock pin shifts the data pin level into bit 0 of the 22-bit shift register. Every other bit moves up one place, and bit 21 is discarded. A word sent most significant bit first therefore ends up with its first bit at position 21.
- R3: On a load, address bits [1:0] of the shift register select the destination register. Code 0 selects register 0, code 1 selects register 1, code 2 selects register 2 and code 3 selects register 3. Register k appears on latch_q_o[20k+19:20k].
- R4: A load stores shift register bits [21:2] into bits [19:0] of the selected register. The address bits are not stored.
- R5: A load changes only the addressed register, and only that register's strobe bit pulses.
- R6: Each rising edge of the load pin causes exactly one load. Serial clock edges while the load pin stays high still shift data, but they cause no further load.
- R7: Each update strobe pulse lasts exactly one system clock cycle.
- R8: shift_view_o always presents the current shift register contents.
- R9: While the load pin stays low, the setting registers keep their values. A register keeps its value until a later load addressed to it overwrites it.
- R10: Changes on the data pin without a serial clock rising edge leave the shift register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock pin (asynchronous) |
| ser_data_i | input | 1 | Serial data pin (asynchronous) |
| ser_le_i | input | 1 | Load strobe pin (asynchronous) |
| shift_view_o | output | 22 | Diagnostic copy of the shift register |
| latch_q_o | output | 80 | Four 20-bit setting registers; register k at bits [20k+19:20k] |
| upd_stb_o | output | 4 | One-cycle update strobe, one bit per register |

## Verification
The assertions assume that each pin level is held for longer than the synchronizer depth plus one system clock cycle. They also assume that the load pin and the serial clock pin never rise in the same synchronized cycle. Under those conditions, each detected edge is a lone single-cycle pulse, and shifting never coincides with loading. The stimulus meets these conditions by changing one pin at a time on a falling system clock edge, then waiting six system clock cycles before the next pin change. The data pin is always settled before the serial clock rises.

// File: rtl/synth_cfg_pkg.sv
// Package: shared sizing defaults for the synthesizer serial control port.
// Assumes: nothing; constants only.
package synth_cfg_pkg;
    localparam int CFG_WORD_W     = 22;   // bits held by the shift register
    localparam int CFG_ADDR_W     = 2;    // address field at the word's low end
    localparam int CFG_SYNC_DEPTH = 2;    // flops per pin synchronizer
endpackage

// File: rtl/cfg_pin_sync.sv
// Module: cfg_pin_sync
// Brings W asynchronous pins into the clk domain through a chain of
// DEPTH flops per pin. Assumes: DEPTH >= 2 and pins held for several cycles.
module cfg_pin_sync #(
    parameter int W     = 3,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] chain [DEPTH];

    // Shift the pin samples down the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) chain[k] <= '0;
        end else begin
            chain[0] <= pin_i;
            for (int k = 1; k < DEPTH; k++) chain[k] <= chain[k-1];
        end
    end

    assign lvl_o = chain[DEPTH-1];
endmodule

// File: rtl/cfg_rise_detect.sv
// Module: cfg_rise_detect
// Produces a one-cycle pulse for each low-to-high change of W synchronized
// levels. Assumes: inputs are already in the clk domain.
module cfg_rise_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o & $past(rise_o)) == '0); // R6
endmodule

// File: rtl/cfg_shifter.sv
// Module: cfg_shifter
// W-bit shift register; on shift_en the new bit enters at bit 0 and the
// oldest bit leaves from the top. Assumes: shift_en is a one-cycle pulse.
module cfg_shifter #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    // Move one bit in per shift request.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_o <= '0;
        else if (shift_en) word_o <= {word_o[W-2:0], bit_i};
    end

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> word_o[W-1:1] == $past(word_o[W-2:0])); // R2
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word_o)); // R10
endmodule

// File: rtl/cfg_latch_bank.sv
// Module: cfg_latch_bank
// Holds 2**ADDR_W setting registers of PAY_W bits. On load_en, the word's
// payload goes to the register named by its low ADDR_W bits, and that
// register's strobe pulses once. Assumes: load_en is a one-cycle pulse.
module cfg_latch_bank #(
    parameter int ADDR_W = 2,
    parameter int PAY_W  = 20,
    localparam int N_REG  = 1 << ADDR_W,
    localparam int WORD_W = PAY_W + ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [WORD_W-1:0]      word_i,
    output logic [N_REG*PAY_W-1:0] q_o,
    output logic [N_REG-1:0]       stb_o
);
    logic [ADDR_W-1:0] addr;
    logic [PAY_W-1:0]  payload;

    assign addr    = word_i[ADDR_W-1:0];
    assign payload = word_i[WORD_W-1:ADDR_W];

    for (genvar g = 0; g < N_REG; g++) begin : g_slot
        logic hit;
        assign hit = load_en && (addr == ADDR_W'(g));

        // Capture the payload and raise this slot's strobe on an addressed load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_o[g*PAY_W +: PAY_W] <= '0;
                stb_o[g]              <= 1'b0;
            end else begin
                stb_o[g] <= hit;
                if (hit) q_o[g*PAY_W +: PAY_W] <= payload;
            end
        end

        AST_PAYLOAD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
            stb_o[g] |-> q_o[g*PAY_W +: PAY_W] == $past(word_i[WORD_W-1:ADDR_W])); // R4
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb_o)); // R5
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (|stb_o) |=> !(|stb_o)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(q_o)); // R9
endmodule

// File: rtl/synth_cfg_port.sv
// Module: synth_cfg_port (top)
// Serial control port: synchronizes the three host pins, shifts the data
// pin on serial clock rises and routes the payload to one of four
// setting registers on load strobe rises. Assumes: each pin level is held
// for more than SYNC_DEPTH+1 clk cycles, and the load strobe and serial
// clock never rise together.
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int WORD_W     = CFG_WORD_W,
    parameter int ADDR_W     = CFG_ADDR_W,
    parameter int SYNC_DEPTH = CFG_SYNC_DEPTH,
    localparam int PAY_W = WORD_W - ADDR_W,
    localparam int N_REG = 1 << ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk_i,
    input  logic                   ser_data_i,
    input  logic                   ser_le_i,
    output logic [WORD_W-1:0]      shift_view_o,
    output logic [N_REG*PAY_W-1:0] latch_q_o,
    output logic [N_REG-1:0]       upd_stb_o
);
    logic [2:0]        pin_lvl;   // {load, data, sclk}
    logic [1:0]        pin_rise;  // {load, sclk}
    logic [WORD_W-1:0] sr_word;

    cfg_pin_sync #(.W(3), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ser_le_i, ser_data_i, ser_clk_i}),
        .lvl_o (pin_lvl)
    );

    cfg_rise_detect #(.W(2)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({pin_lvl[2], pin_lvl[0]}),
        .rise_o (pin_rise)
    );

    cfg_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (pin_rise[0]),
        .bit_i    (pin_lvl[1]),
        .word_o   (sr_word)
    );

    cfg_latch_bank #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (pin_rise[1]),
        .word_i  (sr_word),
        .q_o     (latch_q_o),
        .stb_o   (upd_stb_o)
    );

    assign shift_view_o = sr_word;

    AST_LOAD_NOT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_stb_o) |-> $stable(shift_view_o)); // R6
endmodule

// File: tb/synth_cfg_port_bench.sv
// Bench for synth_cfg_port: a vector table of words walked by one loop,
// then directed tests for reset and corner cases.
module synth_cfg_port_bench;
    localparam int HOLD = 6;
    localparam int NV   = 6;
    localparam logic [19:0] V_PAY  [NV] = '{20'hABCDE, 20'h13579, 20'hFFFFF,
                                            20'h80001, 20'h00000, 20'h5A5A5};
    localparam logic [1:0]  V_ADDR [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [21:0] shift_view;
    logic [79:0] latch_q;
    logic [3:0]  upd_stb;

    int n_cmp = 0, n_bad = 0;
    int stb_cnt [4] = '{0, 0, 0, 0};
    int wide_cnt = 0;
    logic [3:0] stb_prev = '0;
    logic [19:0] model [4] = '{20'h0, 20'h0, 20'h0, 20'h0};
    bit done = 1'b0;

    always #10 clk = ~clk;

    synth_cfg_port u_synth_cfg_port (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
        .ser_le_i(ser_le), .shift_view_o(shift_view), .latch_q_o(latch_q),
        .upd_stb_o(upd_stb)
    );

    // Count strobes per register and flag any pulse wider than one cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++) if (upd_stb[i]) stb_cnt[i]++;
            if ((|upd_stb) && (|stb_prev)) wide_cnt++;
        end
        stb_prev = upd_stb;
    end

    task automatic check(input string req, input logic [79:0] got, input logic [79:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;   wait_cyc(HOLD);
        ser_clk  = 1'b1; wait_cyc(HOLD);
        ser_clk  = 1'b0; wait_cyc(HOLD);
    endtask

    task automatic send_word(input logic [21:0] w);
        for (int i = 21; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_le();
        ser_le = 1'b1; wait_cyc(HOLD);
        ser_le = 1'b0; wait_cyc(HOLD);
    endtask

    function automatic logic [79:0] model_flat();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    function automatic int stb_total();
        return stb_cnt[0] + stb_cnt[1] + stb_cnt[2] + stb_cnt[3];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [21:0] w;
        logic [79:0] snap_q;
        int before_t, before_s;

        // R1: reset state
        wait_cyc(5);
        check("R1 shift view", 80'(shift_view), 80'h0);
        check("R1 latches", latch_q, 80'h0);
        check("R1 strobes", 80'(upd_stb), 80'h0);
        rst_n = 1'b1;
        wait_cyc(2);

        // Table walk: R2/R8 shift view, R3/R4/R5 routing, one strobe each
        for (int v = 0; v < NV; v++) begin
            w = {V_PAY[v], V_ADDR[v]};
            send_word(w);
            check("R8 R2 shift view after word", 80'(shift_view), 80'(w));
            before_t = stb_total();
            before_s = stb_cnt[V_ADDR[v]];
            pulse_le();
            model[V_ADDR[v]] = V_PAY[v];
            check("R3 R4 R5 latch contents", latch_q, model_flat());
            check("R5 addressed strobe once", 80'(stb_cnt[V_ADDR[v]] - before_s), 80'd1);
            check("R5 no other strobe", 80'(stb_total() - before_t), 80'd1);
        end

        // R6: shifting while load held high gives no further load
        w = shift_view;
        before_t = stb_total();
        ser_le = 1'b1; wait_cyc(HOLD);
        snap_q = latch_q;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        check("R6 shift continues with load high", 80'(shift_view), 80'({w[18:0], 3'b101}));
        check("R6 latches unchanged with load high", latch_q, snap_q);
        check("R6 single load per rise", 80'(stb_total() - before_t), 80'd1);
        ser_le = 1'b0; wait_cyc(HOLD);

        // R10: data toggles without serial clock
        w = shift_view;
        for (int i = 0; i < 5; i++) begin ser_data = ~ser_data; wait_cyc(HOLD); end
        check("R10 shift view stable", 80'(shift_view), 80'(w));

        // R9: new word shifted with load low leaves latches and strobes alone
        snap_q = latch_q;
        before_t = stb_total();
        send_word({20'h77777, 2'd2});
        check("R9 latches hold", latch_q, snap_q);
        check("R9 no strobe", 80'(stb_total() - before_t), 80'd0);

        // R2: overflow drops oldest bits
        send_word(22'h3FFFFF);
        send_bit(1'b0); send_bit(1'b0);
        check("R2 oldest bits discarded", 80'(shift_view), 80'h3FFFFC);

        // R7: strobe width
        check("R7 strobe width one cycle", 80'(wide_cnt), 80'd0);

        // R1: reset in mid operation
        rst_n = 1'b0; wait_cyc(3);
        check("R1 mid reset latches", latch_q, 80'h0);
        check("R1 mid reset shift view", 80'(shift_view), 80'h0);
        rst_n = 1'b1; wait_cyc(2);
        model = '{20'h0, 20'h0, 20'h0, 20'h0};

        // R3: load after reset lands in register 2 only
        send_word({20'h2468A, 2'd2});
        pulse_le();
        model[2] = 20'h2468A;
        check("R3 load after reset", latch_q, model_flat());

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule